// File: doc/BRIEF.md
# SPI Serial SRAM Burst Reader

This block is the transaction sequencer in front of a byte-wide SPI master that talks to a serial SRAM. A client issues one request that carries an operation code, a 24-bit memory address, a burst length and a write byte. The sequencer then does four things in order:

- It pulls its own chip select low and keeps it low for the whole operation.
- It waits a short setup interval.
- It hands bytes one at a time to the SPI master: the command, then the three address bytes, then either filler bytes or the write byte.
- It collects the byte the master returns for each one.

The bytes that come back while the command and address go out carry no data. They are dropped by position count. The bytes that come back during the data phase of a read are written into a local buffer, in order, starting at buffer address zero.

A single-byte write and a single-byte read exist beside the burst read. When the operation ends, the block pulses a completion flag for one cycle and releases chip select on the next cycle. The serial clock generation and the bit shifting are left to the SPI master. The byte handshake allows exactly one byte in flight: the sequencer offers a byte until the master accepts it, then waits for the matching received byte before it offers the next.

Top module: `sram_burst_reader`

## Requirements
- R1: While reset is held and right after it, cs_n is 1 and busy, done, xfer_valid and buf_we are 0.
- R2: A burst read (req_op = 2'b01) sends, in this order, 8'h03, then address bits 23:16, 15:8 and 7:0, then exactly req_len filler bytes equal to DUMMY (default 8'h00). cs_n stays 0 for the whole sequence.
- R3: No byte is offered (xfer_valid) while cs_n is 1. The first byte of an operation is offered no earlier than SETUP_CYC cycles after cs_n falls.
- R4: The bytes received for the four command and address positions are never written to the buffer.
- R5: The k-th byte received in the data phase of a read is written to buffer address k, counting from 0. The addresses are written in increasing order, each exactly once, with the received value.
- R6: Burst lengths up to MAX_LEN are supported, including 640 and MAX_LEN itself (default 1024).
- R7: After the final received byte, done is 1 for exactly one cycle with cs_n still 0. On the next cycle cs_n is 1 and busy is 0.
- R8: A single write (req_op = 2'b11) sends 8'h02, the three address bytes and then req_wdata. All of its received bytes are discarded.
- R9: A single read (req_op = 2'b10) sends 8'h03, the three address bytes and one filler byte. It writes the one returned byte to buffer address 0.
- R10: A request presented while busy is 1 is ignored. The running operation continues unchanged and completes once.
- R11: A request is ignored in three cases: req_op = 2'b00, or a burst with req_len of 0, or a burst with req_len above MAX_LEN. In each case cs_n stays 1.
- R12: While xfer_valid is 1 and xfer_ready is 0, xfer_tx holds steady. No new byte is offered until the received byte for the previous one has arrived (rx_valid).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 01 burst read, 10 single read, 11 single write, 00 none |
| req_addr | input | 24 | Memory start address |
| req_len | input | $clog2(MAX_LEN+1) | Burst length in bytes |
| req_wdata | input | 8 | Byte for a single write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Memory chip select, active low |
| xfer_valid | output | 1 | Byte offered to the SPI master |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ready | input | 1 | SPI master accepts the offered byte |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | $clog2(MAX_LEN) | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |

## Verification
Each failure mode of the internal state shows at the ports within one byte exchange:

- A wrong byte index gives a wrong command or address byte on xfer_tx.
- A header byte that leaks into the buffer gives a buf_we during the first four exchanges.
- A data phase that is one too long or too short gives a wrong count of buffer writes, or a done pulse one exchange early or late.

A chip select released early shows as a rise of cs_n before done. A setup counter that is off by one shows as a first offer too soon after cs_n falls. The bench models the memory itself, sweeps burst lengths and addresses, includes an address wrap and the longest bursts, and reads back writes through the same ports.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_BITS  = 8 * ADDR_BYTES;
    localparam int HDR_BYTES  = ADDR_BYTES + 1;

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_BURST = 2'b01,
        OP_RD1   = 2'b10,
        OP_WR1   = 2'b11
    } sram_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SEND  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } seq_st_e;

endpackage

// File: rtl/sram_step_ctr.sv
module sram_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/sram_hdr_sel.sv
module sram_hdr_sel
    import sram_rd_pkg::*;
(
    input  sram_op_e                op,
    input  logic [ADDR_BITS-1:0]    addr,
    input  logic [1:0]              sel,
    output logic [7:0]              hdr_byte
);

    logic [7:0] lanes [HDR_BYTES];

    // Lane 0 carries the command, lanes 1..3 the address, most significant first.
    assign lanes[0] = (op == OP_WR1) ? CMD_WRITE : CMD_READ;

    generate
        for (genvar g = 1; g < HDR_BYTES; g++) begin : g_addr_lane
            assign lanes[g] = addr[ADDR_BITS-1-8*(g-1) -: 8];
        end
    endgenerate

    assign hdr_byte = lanes[sel];

endmodule

// File: rtl/sram_burst_reader.sv
module sram_burst_reader
    import sram_rd_pkg::*;
#(
    parameter int         MAX_LEN   = 1024,
    parameter int         SETUP_CYC = 2,
    parameter logic [7:0] DUMMY     = 8'h00,
    localparam int        LEN_W     = $clog2(MAX_LEN + 1),
    localparam int        BUF_AW    = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_wdata,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              xfer_valid,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);

    localparam int IDX_W = $clog2(MAX_LEN + HDR_BYTES + 1);
    localparam int SET_W = $clog2(SETUP_CYC + 1);

    typedef struct packed {
        seq_st_e              st;
        logic                 cs_n;
        sram_op_e             op;
        logic [ADDR_BITS-1:0] addr;
        logic [LEN_W-1:0]     len;
        logic [7:0]           wdata;
        logic                 buf_we;
        logic [BUF_AW-1:0]    buf_addr;
        logic [7:0]           buf_wdata;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic             idx_clr;
    logic             idx_inc;
    logic             set_clr;
    logic             set_inc;
    logic [IDX_W-1:0] idx;
    logic [SET_W-1:0] set_cnt;
    logic [7:0]       hdr_byte;

    sram_step_ctr #(.W(IDX_W)) i_idx_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .cnt   (idx)
    );

    sram_step_ctr #(.W(SET_W)) i_setup_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (set_clr),
        .inc   (set_inc),
        .cnt   (set_cnt)
    );

    sram_hdr_sel i_hdr_sel (
        .op       (seq_q.op),
        .addr     (seq_q.addr),
        .sel      (idx[1:0]),
        .hdr_byte (hdr_byte)
    );

    // Request qualification
    sram_op_e op_in;
    logic     len_bad;
    logic     req_ok;

    assign op_in   = sram_op_e'(req_op);
    assign len_bad = (req_len == '0) || (req_len > LEN_W'(MAX_LEN));
    assign req_ok  = req_valid && (op_in != OP_NONE) && !((op_in == OP_BURST) && len_bad);

    // Position bookkeeping
    logic             in_data;
    logic [IDX_W-1:0] data_idx;
    logic [IDX_W-1:0] payload;
    logic [IDX_W-1:0] last_idx;

    assign in_data  = idx >= IDX_W'(HDR_BYTES);
    assign data_idx = idx - IDX_W'(HDR_BYTES);
    assign payload  = (seq_q.op == OP_BURST) ? IDX_W'(seq_q.len) : IDX_W'(1);
    assign last_idx = payload + IDX_W'(HDR_BYTES - 1);

    always_comb begin
        seq_d        = seq_q;
        seq_d.buf_we = 1'b0;
        idx_clr      = 1'b0;
        idx_inc      = 1'b0;
        set_clr      = 1'b0;
        set_inc      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_ok) begin
                    seq_d.st    = ST_SETUP;
                    seq_d.cs_n  = 1'b0;
                    seq_d.op    = op_in;
                    seq_d.addr  = req_addr;
                    seq_d.len   = req_len;
                    seq_d.wdata = req_wdata;
                    idx_clr     = 1'b1;
                    set_clr     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (set_cnt == SET_W'(SETUP_CYC - 1)) begin
                    seq_d.st = ST_SEND;
                end else begin
                    set_inc = 1'b1;
                end
            end
            ST_SEND: begin
                if (xfer_ready) begin
                    seq_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    if (in_data && (seq_q.op != OP_WR1)) begin
                        seq_d.buf_we    = 1'b1;
                        seq_d.buf_addr  = data_idx[BUF_AW-1:0];
                        seq_d.buf_wdata = rx_data;
                    end
                    if (idx == last_idx) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        idx_inc  = 1'b1;
                        seq_d.st = ST_SEND;
                    end
                end
            end
            ST_DONE: begin
                seq_d.st   = ST_IDLE;
                seq_d.cs_n = 1'b1;
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.cs_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = seq_q.st != ST_IDLE;
    assign done       = seq_q.st == ST_DONE;
    assign cs_n       = seq_q.cs_n;
    assign xfer_valid = seq_q.st == ST_SEND;
    assign xfer_tx    = !in_data ? hdr_byte :
                        (seq_q.op == OP_WR1) ? seq_q.wdata : DUMMY;
    assign buf_we     = seq_q.buf_we;
    assign buf_addr   = seq_q.buf_addr;
    assign buf_wdata  = seq_q.buf_wdata;

    AST_CS_COVERS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !cs_n);                                                  // R3
    AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !xfer_valid);                                           // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_tx)));      // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cs_n && !busy));                                     // R7
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(done));                                           // R7
    AST_WE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !cs_n);                                                      // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!xfer_valid && !buf_we && !done));                            // R11

endmodule

// File: tb/test_sram_burst_reader.sv
module test_sram_burst_reader;

    localparam int MEM_N = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [23:0] req_addr = '0;
    logic [10:0] req_len = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, cs_n, xfer_valid, buf_we;
    logic [7:0]  xfer_tx, buf_wdata;
    logic        xfer_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [9:0]  buf_addr;

    always #4 clk = ~clk;

    sram_burst_reader i_sram_burst_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .busy(busy), .done(done), .cs_n(cs_n), .xfer_valid(xfer_valid),
        .xfer_tx(xfer_tx), .xfer_ready(xfer_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    int checks = 0;
    int errors = 0;

    // memory model and independent expectation
    logic [7:0] mem     [MEM_N];
    logic [7:0] exp_mem [MEM_N];
    logic [7:0] tx_log  [1100];
    logic [7:0] cap     [1024];

    int cyc = 0, tx_n = 0, wr_n = 0, done_n = 0, fall_n = 0;
    int viol_cs = 0, viol_one = 0, seq_bad = 0, we_cs_bad = 0, done_cs_bad = 0;
    int fall_cyc = 0, gap = -1, done_cyc = 0, rise_cyc = 0;
    bit seen_first = 0, prev_cs = 1, wd_fired = 0;
    bit pend = 0;
    int lat = 0, stall = 0, frame_k = 0;
    logic [7:0]  f_cmd = '0, resp = '0;
    logic [23:0] f_addr = '0;

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd_fired) begin
            wd_fired = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not end, act %0d cycles exp < 150000", cyc);
            summary_and_end();
        end
        if (rst_n) begin
            // monitor
            if (xfer_valid && cs_n) viol_cs++;
            if (xfer_valid && pend) viol_one++;
            if (prev_cs && !cs_n) begin fall_cyc = cyc; fall_n++; end
            if (!prev_cs && cs_n) rise_cyc = cyc;
            if (xfer_valid && !seen_first) begin seen_first = 1; gap = cyc - fall_cyc; end
            if (done) begin done_n++; done_cyc = cyc; if (cs_n) done_cs_bad++; end
            if (buf_we) begin
                if (int'(buf_addr) != wr_n) seq_bad++;
                if (cs_n) we_cs_bad++;
                cap[buf_addr] = buf_wdata;
                wr_n++;
            end
            prev_cs = cs_n;
            if (cs_n) frame_k = 0;
            // SPI master + memory model
            xfer_ready = 1'b0;
            rx_valid   = 1'b0;
            if (pend) begin
                if (lat == 0) begin rx_valid = 1'b1; rx_data = resp; pend = 0; end
                else lat--;
            end else if (xfer_valid) begin
                if (stall > 0) stall--;
                else begin
                    xfer_ready = 1'b1;
                    tx_log[tx_n] = xfer_tx;
                    tx_n++;
                    resp = 8'hA5;
                    if (frame_k == 0) f_cmd = xfer_tx;
                    else if (frame_k < 4) f_addr = {f_addr[15:0], xfer_tx};
                    else if (f_cmd == 8'h03) resp = mem[(int'(f_addr) + frame_k - 4) % MEM_N];
                    else if (f_cmd == 8'h02 && frame_k == 4) mem[int'(f_addr) % MEM_N] = xfer_tx;
                    frame_k++;
                    pend  = 1;
                    lat   = tx_n % 3;
                    stall = tx_n % 2;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        tx_n = 0; wr_n = 0; done_n = 0; fall_n = 0; viol_cs = 0; viol_one = 0;
        seq_bad = 0; we_cs_bad = 0; done_cs_bad = 0; gap = -1; seen_first = 0;
    endtask

    // op: 1 burst, 2 single read, 3 single write
    task automatic run_op(int op, int addr, int len, int wd, string tag, bit inject);
        int n_exp, k, bad_k;
        logic [7:0] e;
        @(negedge clk);
        clear_mon();
        req_valid = 1'b1; req_op = 2'(op); req_addr = 24'(addr);
        req_len = 11'(len); req_wdata = 8'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (done_n == 0 && k < 20000) begin
            @(negedge clk);
            k++;
            if (inject && k == 30) begin
                req_valid = 1'b1; req_op = 2'b11; req_addr = 24'h000300; req_len = 11'd1; req_wdata = 8'hEE;
            end else req_valid = 1'b0;
        end
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_exp = (op == 1) ? 4 + len : 5;
        chk(done_n == 1, "R7", "done pulse count", done_n, 1);
        chk(done_cs_bad == 0, "R7", "done with cs_n high", done_cs_bad, 0);
        chk(rise_cyc == done_cyc + 1, "R7", "cs_n rise cycle after done", rise_cyc - done_cyc, 1);
        chk(!busy && cs_n, "R7", "idle after done", int'(busy), 0);
        chk(tx_n == n_exp, tag, "bytes sent", tx_n, n_exp);
        bad_k = -1;
        for (int i = 0; i < n_exp && i < tx_n; i++) begin
            case (i)
                0: e = (op == 3) ? 8'h02 : 8'h03;
                1: e = 8'(addr >> 16);
                2: e = 8'(addr >> 8);
                3: e = 8'(addr);
                default: e = (op == 3) ? 8'(wd) : 8'h00;
            endcase
            if (tx_log[i] !== e && bad_k < 0) bad_k = i;
        end
        chk(bad_k < 0, tag, "tx byte mismatch at index", bad_k, -1);
        chk(gap >= 2, "R3", "cs_n fall to first offer", gap, 2);
        chk(viol_cs == 0, "R3", "offers with cs_n high", viol_cs, 0);
        chk(viol_one == 0, "R12", "offers while byte outstanding", viol_one, 0);
        chk(fall_n == 1, inject ? "R10" : "R2", "cs_n assertions", fall_n, 1);
        if (op == 3) begin
            chk(wr_n == 0, "R8", "buffer writes on single write", wr_n, 0);
            exp_mem[addr % MEM_N] = 8'(wd);
        end else begin
            chk(wr_n == ((op == 1) ? len : 1), "R4", "buffer write count", wr_n, (op == 1) ? len : 1);
            chk(seq_bad == 0 && we_cs_bad == 0, "R5", "buffer address order", seq_bad, 0);
            bad_k = -1;
            for (int i = 0; i < wr_n && i < 1024; i++)
                if (cap[i] !== exp_mem[(addr + i) % MEM_N] && bad_k < 0) bad_k = i;
            chk(bad_k < 0, (op == 2) ? "R9" : "R5", "buffer data mismatch at", bad_k, -1);
        end
    endtask

    task automatic run_ignored(int op, int len, string tag);
        @(negedge clk);
        clear_mon();
        req_valid = 1'b1; req_op = 2'(op); req_addr = 24'h000100; req_len = 11'(len);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(fall_n == 0 && cs_n, tag, "cs_n asserted for ignored request", fall_n, 0);
        chk(!busy && done_n == 0 && tx_n == 0, tag, "activity for ignored request", tx_n + done_n, 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 8'hFF);
            exp_mem[i] = 8'((i * 37 + 11) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        chk(cs_n && !busy && !done && !xfer_valid && !buf_we, "R1", "outputs in reset", int'(cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !busy && !done && !xfer_valid && !buf_we, "R1", "outputs after reset", int'(busy), 0);
        // burst length sweep, R2 / R5
        for (int n = 1; n <= 12; n++) run_op(1, n * 103 + 7, n, 0, "R2", 0);
        run_op(1, 24'hFFFFFE, 5, 0, "R2", 0);        // address wrap
        run_op(1, 24'h001234, 640, 0, "R6", 0);
        run_op(1, 24'h000400, 1024, 0, "R6", 0);
        // single write then reads
        run_op(3, 24'h000202, 1, 8'h5C, "R8", 0);
        run_op(2, 24'h000202, 1, 0, "R9", 0);
        run_op(1, 24'h000200, 8, 0, "R5", 0);
        for (int a = 0; a < 4; a++) run_op(2, a * 777 + 5, 1, 0, "R9", 0);
        // request while busy ignored; injected write must not land
        run_op(1, 24'h000050, 40, 0, "R10", 1);
        run_op(2, 24'h000300, 1, 0, "R10", 0);
        // ignored requests
        run_ignored(1, 0, "R11");
        run_ignored(1, 1025, "R11");
        run_ignored(0, 4, "R11");
        summary_and_end();
    end

endmodule